// File: doc/BRIEF.md
# Banked Page-Register Address Translator

This block widens a 16-bit processor logical address into a 20-bit physical address. Physical memory is seen as 256 frames of 4K words. The upper eight bits of the physical address come from a page register. The low twelve bits are the in-page offset and pass through untouched.

There are two independent files of 256 eight-bit page registers. One file serves instruction fetches and the other serves operand accesses. The register index is built from the processor's 4-bit address state and the page nibble of the logical address. A data/instruction flag picks which file drives the extended page.

Software loads registers through a clocked write port and reads them back combinationally. A synchronous reset puts both files into an identity mapping, so the block starts out transparent.

Top module: `page_xlate_top`

## Requirements
- R1: `phys_addr[11:0]` always equals `la[11:0]`, and `phys_addr[19:12]` equals `ext_page`.
- R2: The register index used for translation is `{addr_state, la[15:12]}`, with the state as the upper nibble.
- R3: The selected file depends on `is_data`. `is_data`=1 takes the entry from the operand file and `is_data`=0 takes it from the instruction file.
- R4: On a rising clock edge with `wr_en`=1 and `rst`=0, `wr_data` is stored at entry `wr_addr`. The file written is the instruction file when `wr_bank`=1 and the operand file when `wr_bank`=0.
- R5: A write into one file leaves every entry of the other file unchanged.
- R6: `rd_data` shows entry `rd_addr` of the instruction file when `rd_inst`=1 and of the operand file when `rd_inst`=0. It is combinational and needs no clock.
- R7: `rd_sel` follows `rd_req` while `rst`=0 and is 0 while `rst`=1.
- R8: Any rising edge with `rst`=1 loads every entry i of both files with the value i. With this identity mapping, `phys_addr` equals `{addr_state, la}`.
- R9: Writes presented while `rst`=1 have no effect.
- R10: Suppose a write targets the entry currently being translated. Before the write edge the output shows the old value, and from that edge on it shows the new value.
- R11: Translation is combinational with no enable. A change of `la`, `addr_state` or `is_data` appears on `phys_addr` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes and reset |
| rst | input | 1 | Synchronous active-high reset; loads the identity mapping |
| wr_en | input | 1 | Page-register write enable |
| wr_bank | input | 1 | Write target: 1 instruction file, 0 operand file |
| wr_addr | input | 8 | Entry index to write |
| wr_data | input | 8 | Page value to store |
| rd_req | input | 1 | Processor read-back request |
| rd_inst | input | 1 | Read-back source: 1 instruction file, 0 operand file |
| rd_addr | input | 8 | Entry index to read back |
| rd_data | output | 8 | Read-back entry value |
| rd_sel | output | 1 | Read-back data-select strobe |
| la | input | 16 | Processor logical address |
| addr_state | input | 4 | Processor address state |
| is_data | input | 1 | 1 operand access, 0 instruction fetch |
| ext_page | output | 8 | Translated extended page |
| phys_addr | output | 20 | 20-bit physical address |

## Verification
A register write and a live translation can land on the same page entry in the same cycle. The bench sets up a translation on entry 0x52 of the operand file. In the half cycle before the edge it drives a write to that same entry. It then samples `phys_addr` twice: once just before the rising edge, where the old identity value is expected, and once just after it, where the written value is expected. A second coincidence comes from writes issued during reset. The bench reads those entries back after release and expects the identity values.

// File: rtl/pxl_pkg.sv
`timescale 1ns/1ps
package pxl_pkg;
  localparam int LA_W    = 16;
  localparam int OFS_W   = 12;
  localparam int STATE_W = 4;
  localparam int PAGE_W  = 8;

  typedef enum logic {
    BANK_OPR = 1'b0,
    BANK_INS = 1'b1
  } bank_e;
endpackage

// File: rtl/page_bank.sv
`timescale 1ns/1ps
module page_bank #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ta,
  output logic [DATA_W-1:0] td,
  input  logic [IDX_W-1:0]  ra,
  output logic [DATA_W-1:0] rdat
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(i);
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign td   = mem[ta];
  assign rdat = mem[ra];

  AST_RST_IDENT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (td == DATA_W'(ta))); // R8

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(wa)] == $past(wd))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we |=> (mem[$past(ra)] == $past(mem[ra]))); // R5
endmodule

// File: rtl/xlate_path.sv
`timescale 1ns/1ps
module xlate_path #(
  parameter int LA_W    = 16,
  parameter int OFS_W   = 12,
  parameter int STATE_W = 4,
  parameter int PAGE_W  = 8,
  localparam int PN_W   = LA_W - OFS_W,
  localparam int IDX_W  = STATE_W + PN_W,
  localparam int PA_W   = PAGE_W + OFS_W
) (
  input  logic [LA_W-1:0]    la,
  input  logic [STATE_W-1:0] addr_state,
  input  logic               is_data,
  input  logic [PAGE_W-1:0]  ins_page,
  input  logic [PAGE_W-1:0]  opr_page,
  output logic [IDX_W-1:0]   idx,
  output logic [PAGE_W-1:0]  ext_page,
  output logic [PA_W-1:0]    phys_addr
);
  assign idx       = {addr_state, la[LA_W-1:OFS_W]};
  assign ext_page  = is_data ? opr_page : ins_page;
  assign phys_addr = {ext_page, la[OFS_W-1:0]};
endmodule

// File: rtl/page_xlate_top.sv
`timescale 1ns/1ps
module page_xlate_top
  import pxl_pkg::*;
#(
  parameter int LA_W_P    = LA_W,
  parameter int OFS_W_P   = OFS_W,
  parameter int STATE_W_P = STATE_W,
  parameter int PAGE_W_P  = PAGE_W,
  localparam int IDX_W    = STATE_W_P + LA_W_P - OFS_W_P,
  localparam int PA_W     = PAGE_W_P + OFS_W_P
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_bank,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [PAGE_W_P-1:0]  wr_data,
  input  logic                 rd_req,
  input  logic                 rd_inst,
  input  logic [IDX_W-1:0]     rd_addr,
  output logic [PAGE_W_P-1:0]  rd_data,
  output logic                 rd_sel,
  input  logic [LA_W_P-1:0]    la,
  input  logic [STATE_W_P-1:0] addr_state,
  input  logic                 is_data,
  output logic [PAGE_W_P-1:0]  ext_page,
  output logic [PA_W-1:0]      phys_addr
);
  logic [IDX_W-1:0]    x_idx;
  logic [PAGE_W_P-1:0] tr_page [2];
  logic [PAGE_W_P-1:0] rb_page [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    page_bank #(.IDX_W(IDX_W), .DATA_W(PAGE_W_P)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && (wr_bank == b[0])),
      .wa   (wr_addr),
      .wd   (wr_data),
      .ta   (x_idx),
      .td   (tr_page[b]),
      .ra   (rd_addr),
      .rdat (rb_page[b])
    );
  end

  xlate_path #(
    .LA_W(LA_W_P), .OFS_W(OFS_W_P), .STATE_W(STATE_W_P), .PAGE_W(PAGE_W_P)
  ) u_xlate (
    .la         (la),
    .addr_state (addr_state),
    .is_data    (is_data),
    .ins_page   (tr_page[BANK_INS]),
    .opr_page   (tr_page[BANK_OPR]),
    .idx        (x_idx),
    .ext_page   (ext_page),
    .phys_addr  (phys_addr)
  );

  assign rd_data = rd_inst ? rb_page[BANK_INS] : rb_page[BANK_OPR];
  assign rd_sel  = rd_req && !rst;

  AST_PATHS_AGREE: assert property (@(posedge clk) disable iff (rst)
    ((rd_addr == x_idx) && (rd_inst == !is_data)) |-> (rd_data == ext_page)); // R6
endmodule

// File: tb/page_xlate_top_test.sv
`timescale 1ns/1ps
module page_xlate_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_bank = 1'b0;
  logic [7:0]  wr_addr = '0, wr_data = '0;
  logic        rd_req = 1'b0, rd_inst = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_sel;
  logic [15:0] la = '0;
  logic [3:0]  addr_state = '0;
  logic        is_data = 1'b0;
  logic [7:0]  ext_page;
  logic [19:0] phys_addr;

  int total = 0;
  int bad = 0;
  logic [7:0] m_ins [256];
  logic [7:0] m_opr [256];

  always #2 clk = ~clk;

  page_xlate_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_inst(rd_inst), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_sel(rd_sel), .la(la), .addr_state(addr_state),
    .is_data(is_data), .ext_page(ext_page), .phys_addr(phys_addr)
  );

  // {is_data, addr_state, la, expected phys_addr} under identity mapping
  localparam logic [40:0] VEC [6] = '{
    {1'b0, 4'h0, 16'h0000, 20'h00000},
    {1'b1, 4'hF, 16'hFFFF, 20'hFFFFF},
    {1'b0, 4'h3, 16'hA5C3, 20'h3A5C3},
    {1'b1, 4'hC, 16'h1234, 20'hC1234},
    {1'b0, 4'h7, 16'h8001, 20'h78001},
    {1'b1, 4'h1, 16'h0FFF, 20'h10FFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic bank, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = bank; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (!rst) begin
      if (bank) m_ins[a] = d; else m_opr[a] = d;
    end
  endtask

  task automatic readback(input string req, input logic inst, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_inst = inst; rd_addr = a;
    #1 chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic xlate(input string req, input logic d, input logic [3:0] s,
                       input logic [15:0] a, input logic [19:0] exp);
    @(negedge clk);
    is_data = d; addr_state = s; la = a;
    #1 chk(req, {12'h0, phys_addr}, {12'h0, exp});
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_ins[i] = 8'(i); m_opr[i] = 8'(i); end
    rd_req = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R7 rd_sel low in reset", {31'h0, rd_sel}, 32'h0);
    do_write(1'b1, 8'h3A, 8'h99);                     // R9 write during reset
    @(negedge clk); rst = 1'b0;
    #1 chk("R7 rd_sel follows req", {31'h0, rd_sel}, 32'h1);
    rd_req = 1'b0;
    #1 chk("R7 rd_sel drops", {31'h0, rd_sel}, 32'h0);
    readback("R9 reset-time write ignored", 1'b1, 8'h3A, 8'h3A);
    readback("R8 identity ins", 1'b1, 8'hFF, 8'hFF);
    readback("R8 identity opr", 1'b0, 8'h00, 8'h00);

    for (int k = 0; k < 6; k++)
      xlate("R1 R2 R3 R8 identity vector", VEC[k][40], VEC[k][39:36], VEC[k][35:20], VEC[k][19:0]);

    do_write(1'b1, 8'h3A, 8'hC7);
    readback("R4 instruction write", 1'b1, 8'h3A, 8'hC7);
    readback("R5 operand file untouched", 1'b0, 8'h3A, 8'h3A);
    xlate("R3 fetch uses instruction file", 1'b0, 4'h3, 16'hA123, 20'hC7123);
    xlate("R3 data uses operand file", 1'b1, 4'h3, 16'hA123, 20'h3A123);
    do_write(1'b0, 8'h3A, 8'h5E);
    readback("R4 operand write", 1'b0, 8'h3A, 8'h5E);
    readback("R5 instruction file untouched", 1'b1, 8'h3A, 8'hC7);
    xlate("R3 data after operand remap", 1'b1, 4'h3, 16'hA777, 20'h5E777);

    // R10: write and translate the same operand entry 0x52
    xlate("R10 before write", 1'b1, 4'h5, 16'h2ABC, 20'h52ABC);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 1'b0; wr_addr = 8'h52; wr_data = 8'hE1;
    #1 chk("R10 old value before edge", {12'h0, phys_addr}, 32'h52ABC);
    @(posedge clk); #1;
    wr_en = 1'b0; m_opr[8'h52] = 8'hE1;
    chk("R10 new value after edge", {12'h0, phys_addr}, 32'hE1ABC);

    // R11: change inputs with no clock edge in between
    @(negedge clk);
    la = 16'h2001;
    #0.5 chk("R11 offset change no clock", {12'h0, phys_addr}, 32'hE1001);
    is_data = 1'b0;
    #0.5 chk("R11 file change no clock", {12'h0, phys_addr}, 32'h52001);

    for (int n = 0; n < 24; n++) begin
      logic [15:0] ra; logic [3:0] rs; logic rd; logic [7:0] ix;
      ra = 16'($urandom); rs = 4'($urandom); rd = 1'($urandom);
      ix = {rs, ra[15:12]};
      xlate("R1 random offset", rd, rs, ra, {(rd ? m_opr[ix] : m_ins[ix]), ra[11:0]});
    end

    readback("R6 readback remapped", 1'b0, 8'h52, 8'hE1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    readback("R8 reset restores ins", 1'b1, 8'h3A, 8'h3A);
    readback("R8 reset restores opr", 1'b0, 8'h52, 8'h52);
    xlate("R8 identity after reset", 1'b1, 4'h5, 16'h2FFF, 20'h52FFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule